// File: doc/BRIEF.md
# Banked GPIO Controller with Guarded Pin Ownership

This block is a register-mapped general-purpose I/O controller. Its pins are grouped into banks of 32, and a single-cycle 32-bit register port reaches them. For each bank, software can read the driven output levels and the synchronised input levels. It changes outputs through two write-only strobes: one sets bits and one clears them. Each pin also has its own control word, which holds a direction bit, an edge-type field and a debounce field.

Each bank has an ownership word that marks which pins are claimed. A write to that word takes effect only if it directly follows a key write to a global key register. A pin drives its pad only when it is claimed and configured as an output. External levels reach the input status view through a two-flop synchroniser.

Pin `p` lives in bank `p >> 5`, at bit `p[4:0]`. The byte offsets below are relative to the block, and the register port uses the word address `reg_addr[11:2]`.

Top module: `banked_gpio`

## Requirements
- R1: After reset every control word reads 0x001 (input), every output level is 0, every ownership word reads 0xFFFFFFFF, no pad is enabled and the key is not armed.
- R2: A write to the set strobe of bank `b` (offset 0x040 + 4b) forces each output bit whose data bit is 1 to 1 and leaves every other bit unchanged. Reads of 0x000 + 4b, 0x040 + 4b and 0x060 + 4b all return the current output levels of bank `b`.
- R3: A write to the clear strobe of bank `b` (offset 0x060 + 4b) forces each output bit whose data bit is 1 to 0 and leaves every other bit unchanged.
- R4: The control word of pin `p` sits at offset 0x100 + 4p. It stores bit 0 (1 = input, 0 = output), bits [4:3] (edge type: 1 rising, 2 falling, 3 both) and bits [8:5] (debounce). All other bits read as 0.
- R5: A read of offset 0x020 + 4b returns the pin levels of bank `b` as they were two clock edges earlier.
- R6: Writing exactly 0x00A5A501 to offset 0x520 arms the key. The next write to any ownership word (offset 0x500 + 4b) is applied and disarms the key, so a second ownership write without a new key write is ignored.
- R7: An ownership write while the key is disarmed is ignored. A key write of any other value does not arm the key.
- R8: `pad_oe[p]` is 1 exactly when control bit 0 of pin `p` is 0 and ownership bit `p` is 0. `pad_out` carries the output levels whether or not the pad is enabled.
- R9: The output status, interrupt-area (0x080 to 0x0DC) and key offsets read as 0 or ignore writes as follows: interrupt-area and key offsets read 0, and writes to output status or the interrupt area change no state.
- R10: Bank `b` maps to pins 32b to 32b+31, so strobes aimed at bank 1 affect only `pad_out[63:32]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 12 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, available in the same cycle |
| pin_in | input | NUM_BANKS*32 | Asynchronous pad input levels |
| pad_oe | output | NUM_BANKS*32 | Per-pin pad output enable |
| pad_out | output | NUM_BANKS*32 | Per-pin pad output level |

## Verification
A corrupted output level shows up on `pad_out` and in the status reads on the cycle after the offending strobe. A wrongly armed or stale key shows up as an ownership word that reads back changed after a write that should have been dropped. A direction or ownership bit that holds the wrong value appears at once on `pad_oe`. A synchroniser with the wrong depth reads the new pin level one cycle too early or too late.

// File: rtl/banked_gpio.sv
module banked_gpio #(
  parameter int          NUM_BANKS  = 2,
  parameter logic [31:0] UNLOCK_KEY = 32'h00A5_A501
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_wr,
  input  logic [11:0]             reg_addr,
  input  logic [31:0]             reg_wdata,
  output logic [31:0]             reg_rdata,
  input  logic [NUM_BANKS*32-1:0] pin_in,
  output logic [NUM_BANKS*32-1:0] pad_oe,
  output logic [NUM_BANKS*32-1:0] pad_out
);
  localparam int NPINS = NUM_BANKS * 32;
  localparam int PIN_W = $clog2(NPINS);
  localparam logic [8:0] CTRL_MASK = 9'h1F9;

  logic [NPINS-1:0] out_q, prot_q, sync1_q, sync2_q;
  logic [8:0]       ctrl_q [NPINS];
  logic             armed_q;

  logic [9:0] widx, cidx;
  logic [6:0] grp;
  logic [2:0] bsel;
  logic       bank_ok, hit_out, hit_in, hit_set, hit_clr, hit_prot, hit_key, ctrl_hit;
  logic [PIN_W-1:0] pin_sel;

  assign widx     = reg_addr[11:2];
  assign grp      = widx[9:3];
  assign bsel     = widx[2:0];
  assign bank_ok  = ({29'd0, bsel} < 32'(NUM_BANKS));
  assign hit_out  = (grp == 7'h00);
  assign hit_in   = (grp == 7'h01);
  assign hit_set  = (grp == 7'h02);
  assign hit_clr  = (grp == 7'h03);
  assign hit_prot = (grp == 7'h28);
  assign hit_key  = (widx == 10'h148);
  assign cidx     = widx - 10'h040;
  assign ctrl_hit = (widx >= 10'h040) && ({22'd0, cidx} < 32'(NPINS));
  assign pin_sel  = cidx[PIN_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q   <= '0;
      prot_q  <= '1;
      armed_q <= 1'b0;
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      if (reg_wr && bank_ok && hit_set)
        out_q[bsel*32 +: 32] <= out_q[bsel*32 +: 32] | reg_wdata;
      if (reg_wr && bank_ok && hit_clr)
        out_q[bsel*32 +: 32] <= out_q[bsel*32 +: 32] & ~reg_wdata;
      if (reg_wr && hit_key) begin
        if (reg_wdata == UNLOCK_KEY) armed_q <= 1'b1;
      end else if (reg_wr && hit_prot) begin
        armed_q <= 1'b0;
        if (armed_q && bank_ok) prot_q[bsel*32 +: 32] <= reg_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPINS; i++) ctrl_q[i] <= 9'h001;
    end else if (reg_wr && ctrl_hit) begin
      ctrl_q[pin_sel] <= reg_wdata[8:0] & CTRL_MASK;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (bank_ok) begin
      if (hit_out || hit_set || hit_clr) reg_rdata = out_q[bsel*32 +: 32];
      else if (hit_in)                   reg_rdata = sync2_q[bsel*32 +: 32];
      else if (hit_prot)                 reg_rdata = prot_q[bsel*32 +: 32];
    end
    if (ctrl_hit) reg_rdata = {23'd0, ctrl_q[pin_sel]};
  end

  assign pad_out = out_q;

  for (genvar p = 0; p < NPINS; p++) begin : g_oe
    assign pad_oe[p] = ~ctrl_q[p][0] & ~prot_q[p];
  end

  AST_PROT_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(prot_q) |-> $past(armed_q && reg_wr && hit_prot)); // R7

  AST_KEY_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && hit_prot) |=> !armed_q); // R6

  AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && bank_ok && hit_set) |=>
      ((out_q[$past(bsel)*32 +: 32] & $past(reg_wdata)) == $past(reg_wdata))); // R2

  AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && bank_ok && hit_clr) |=>
      ((out_q[$past(bsel)*32 +: 32] & $past(reg_wdata)) == 32'd0)); // R3

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && (hit_set || hit_clr)) |=> $stable(out_q)); // R9
endmodule

// File: tb/banked_gpio_tb.sv
module banked_gpio_tb;
  localparam int NB = 2;
  localparam int NP = NB * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pad_oe, pad_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [63:0] q_exp[$];
  int          q_kind[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  banked_gpio #(.NUM_BANKS(NB)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );

  // kind 0: read data, 1: pad_oe, 2: pad_out
  task automatic expect_rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    q_exp.push_back({32'd0, e}); q_kind.push_back(0); q_tag.push_back(tag);
  endtask

  task automatic expect_pad(input int kind, input logic [63:0] e, input string tag);
    @(negedge clk);
    q_exp.push_back(e); q_kind.push_back(kind); q_tag.push_back(tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  initial begin : monitor
    forever begin
      wait (q_exp.size() > 0);
      #1;
      begin
        logic [63:0] e, act;
        int k;
        string t;
        e = q_exp.pop_front(); k = q_kind.pop_front(); t = q_tag.pop_front();
        act = (k == 0) ? {32'd0, reg_rdata} : (k == 1) ? pad_oe : pad_out;
        n_run++;
        if (act !== e) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", t, act, e);
        end
      end
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_rd(12'h100, 32'h001, "R1 ctrl pin0 after reset");
    expect_rd(12'h17C, 32'h001, "R1 ctrl pin63 after reset");
    expect_rd(12'h000, 32'h0, "R1 outputs after reset");
    expect_rd(12'h504, 32'hFFFF_FFFF, "R1 ownership bank1 after reset");
    expect_pad(1, 64'h0, "R1 pad_oe after reset");

    wr(12'h040, 32'h0000_00F0);
    expect_rd(12'h000, 32'hF0, "R2 status after set");
    wr(12'h040, 32'h0000_0003);
    expect_rd(12'h040, 32'hF3, "R2 zero bits unchanged");
    wr(12'h060, 32'h0000_0030);
    expect_rd(12'h060, 32'hC3, "R3 clear selected bits");
    expect_rd(12'h000, 32'hC3, "R3 status after clear");

    wr(12'h044, 32'h0000_0001);
    expect_pad(2, 64'h0000_0001_0000_00C3, "R10 bank1 strobe maps to upper pins");
    expect_rd(12'h004, 32'h1, "R10 bank1 status");

    wr(12'h114, 32'hFFFF_FFFE);
    expect_rd(12'h114, 32'h0000_01F8, "R4 ctrl fields kept, spare bits zero");
    expect_rd(12'h118, 32'h001, "R4 neighbour ctrl untouched");

    wr(12'h500, 32'h0);
    expect_rd(12'h500, 32'hFFFF_FFFF, "R7 ownership write without key");
    wr(12'h520, 32'h00A5_A500);
    wr(12'h500, 32'h0);
    expect_rd(12'h500, 32'hFFFF_FFFF, "R7 wrong key value");

    wr(12'h520, 32'h00A5_A501);
    wr(12'h500, 32'hFFFF_FFDF);
    expect_rd(12'h500, 32'hFFFF_FFDF, "R6 keyed ownership write");
    wr(12'h500, 32'h0);
    expect_rd(12'h500, 32'hFFFF_FFDF, "R6 key consumed by one write");

    expect_pad(1, 64'h20, "R8 oe for claimed output pin");
    wr(12'h100, 32'h0);
    expect_pad(1, 64'h20, "R8 unclaimed output pin stays off");
    wr(12'h114, 32'h1);
    expect_pad(1, 64'h0, "R8 input pin not driven");
    expect_pad(2, 64'h0000_0001_0000_00C3, "R8 pad_out independent of oe");

    wr(12'h000, 32'hFFFF_FFFF);
    expect_rd(12'h000, 32'hC3, "R9 status write ignored");
    wr(12'h0A0, 32'hFFFF_FFFF);
    expect_rd(12'h0A0, 32'h0, "R9 interrupt area reads zero");
    expect_rd(12'h520, 32'h0, "R9 key register reads zero");
    expect_pad(2, 64'h0000_0001_0000_00C3, "R9 outputs unchanged");

    @(negedge clk);
    pin_in = 64'hDEAD_0000_0000_00A5;
    reg_addr = 12'h020;
    q_exp.push_back(64'h0); q_kind.push_back(0); q_tag.push_back("R5 no edge yet");
    expect_rd(12'h020, 32'h0, "R5 after one edge");
    expect_rd(12'h020, 32'hA5, "R5 after two edges");
    expect_rd(12'h024, 32'hDEAD_0000, "R5 bank1 input");

    @(negedge clk);
    wait (q_exp.size() == 0);
    #2;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : watchdog
    #(200000 * 20);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule